// File: doc/BRIEF.md
# Periodic RTC Alarm Controller

This block keeps four alarm registers (seconds, minutes, hours and day of month), each a BCD value with a repeat-mask flag in bit 7. An external timekeeper supplies the current BCD time and a single-cycle once-per-second strobe. On each strobe the block compares the alarm against the current time. Which fields take part in the comparison depends on the pattern of mask flags, which sets the alarm to repeat monthly, daily, hourly, every minute or every second. When the alarm fires, the block emits a one-cycle interrupt pulse.

Software reaches the registers through a byte-wide port with a two-bit slot address. Every write has its BCD content range-checked for its slot. A write that fails the check is dropped, and the register keeps its previous contents.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: After reset, the four slots read 0x00 (seconds), 0x00 (minutes), 0x00 (hours) and 0x01 (date), and `irq_pulse` is low.
- R2: Slot 0 holds seconds and slot 1 holds minutes. A write to either slot decodes data bits 6:4 as tens and bits 3:0 as units (value = tens*10 + units). When the decoded value is 59 or less, the whole byte is stored, including bit 7, and it reads back on `rd_data` in the cycle after the write.
- R3: Slot 2 holds hours. A write to it decodes bits 5:4 as tens and bits 3:0 as units, and the byte is stored only when the decoded value is 23 or less.
- R4: Slot 3 holds the date. A write to it decodes bit 4 as tens and bits 3:0 as units, and the byte is stored only when the decoded value lies from 1 to 31.
- R5: A write that fails its range check leaves the stored byte of that slot unchanged.
- R6: With all four mask flags clear, a strobe fires the alarm only when seconds (bits 6:0), minutes (bits 6:0), hours (bits 5:0) and date (bits 4:0) all equal the current time.
- R7: With only the date mask set, a strobe fires when seconds, minutes and hours match, whatever the date.
- R8: With the date and hour masks set (minute and second masks clear), a strobe fires when seconds and minutes match.
- R9: With the date, hour and minute masks set and the second mask clear, a strobe fires when seconds match.
- R10: Any other mask pattern makes every strobe fire the alarm.
- R11: `irq_pulse` goes high for exactly one clock, in the cycle after a firing strobe is sampled. It never goes high without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Slot select: 0 sec, 1 min, 2 hour, 3 date |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Stored byte of the selected slot (combinational) |
| sec_tick | input | 1 | One-cycle once-per-second strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq_pulse | output | 1 | Alarm interrupt pulse |

## Verification
Each repeat rate is driven with a strobe at which every compared field matches. It is also driven with strobes that break exactly one field: a field the rate compares, or a field the rate ignores. Together these show which fields each mask pattern really involves. A pattern outside the four named ones is given a time that matches nothing, which separates the fall-through case from the monthly case. Writes just inside and just outside each slot's range, including a units nibble above nine and a zero date, separate an accepted write from a dropped one.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SLOT_SEC  = 2'd0,
        SLOT_MIN  = 2'd1,
        SLOT_HOUR = 2'd2,
        SLOT_DATE = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        RATE_MONTH,
        RATE_DAY,
        RATE_HOUR,
        RATE_MIN,
        RATE_SEC
    } rate_e;

    typedef struct packed {
        logic [DATA_W-1:0] date;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] sec;
    } alarm_t;

    // tens*10 + units; widest case 7*10+15 fits in 7 bits
    function automatic logic [6:0] bcd_dec(input logic [2:0] tens, input logic [3:0] units);
        return (7'(tens) * 7'd10) + 7'(units);
    endfunction

    function automatic logic slot_ok(input slot_e slot, input logic [DATA_W-1:0] v);
        logic [6:0] n;
        case (slot)
            SLOT_SEC, SLOT_MIN: begin
                n = bcd_dec(v[6:4], v[3:0]);
                return n <= 7'd59;
            end
            SLOT_HOUR: begin
                n = bcd_dec({1'b0, v[5:4]}, v[3:0]);
                return n <= 7'd23;
            end
            default: begin
                n = bcd_dec({2'b00, v[4]}, v[3:0]);
                return (n >= 7'd1) && (n <= 7'd31);
            end
        endcase
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_DATE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output alarm_t            alm
);

    slot_e slot;
    logic  accept;

    assign slot   = slot_e'(reg_addr);
    assign accept = wr_en && slot_ok(slot, wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            alm.sec  <= '0;
            alm.min  <= '0;
            alm.hour <= '0;
            alm.date <= RST_DATE;
        end else if (accept) begin
            case (slot)
                SLOT_SEC:  alm.sec  <= wr_data;
                SLOT_MIN:  alm.min  <= wr_data;
                SLOT_HOUR: alm.hour <= wr_data;
                default:   alm.date <= wr_data;
            endcase
        end
    end

    always_comb begin
        case (slot)
            SLOT_SEC:  rd_data = alm.sec;
            SLOT_MIN:  rd_data = alm.min;
            SLOT_HOUR: rd_data = alm.hour;
            default:   rd_data = alm.date;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  alarm_t alm,
    input  alarm_t now,
    output rate_e  rate,
    output logic   hit
);

    logic [3:0] masks;
    logic       eq_sec, eq_min, eq_hour, eq_date;

    assign masks   = {alm.sec[7], alm.min[7], alm.hour[7], alm.date[7]};
    assign eq_sec  = alm.sec[6:0]  == now.sec[6:0];
    assign eq_min  = alm.min[6:0]  == now.min[6:0];
    assign eq_hour = alm.hour[5:0] == now.hour[5:0];
    assign eq_date = alm.date[4:0] == now.date[4:0];

    always_comb begin
        case (masks)
            4'b0000: rate = RATE_MONTH;
            4'b0001: rate = RATE_DAY;
            4'b0011: rate = RATE_HOUR;
            4'b0111: rate = RATE_MIN;
            default: rate = RATE_SEC;
        endcase
    end

    always_comb begin
        case (rate)
            RATE_MONTH: hit = eq_sec && eq_min && eq_hour && eq_date;
            RATE_DAY:   hit = eq_sec && eq_min && eq_hour;
            RATE_HOUR:  hit = eq_sec && eq_min;
            RATE_MIN:   hit = eq_sec;
            default:    hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
    import rtc_alarm_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_DATE = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sec_tick,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic [DATA_W-1:0] cur_date,
    output logic              irq_pulse
);

    alarm_t alm_q;
    alarm_t now;
    rate_e  rate;
    logic   hit;
    logic   irq_q;

    assign now = '{date: cur_date, hour: cur_hour, min: cur_min, sec: cur_sec};

    rtc_alarm_regs #(.RST_DATE(RST_DATE)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .alm      (alm_q)
    );

    rtc_alarm_match match_i (
        .alm  (alm_q),
        .now  (now),
        .rate (rate),
        .hit  (hit)
    );

    // compare once per strobe; strobe is one cycle so each match gives one pulse
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= sec_tick && hit;
    end

    assign irq_pulse = irq_q;

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              sec_tick,
    input logic [DATA_W-1:0] cur_date,
    input logic              irq_pulse,
    input alarm_t            alm_q
);

    logic [6:0] w_sec_n;
    logic [6:0] w_hour_n;
    logic       no_masks;

    assign w_sec_n  = {3'b000, wr_data[6:4]} * 7'd10 + {3'b000, wr_data[3:0]};
    assign w_hour_n = {5'b00000, wr_data[5:4]} * 7'd10 + {3'b000, wr_data[3:0]};
    assign no_masks = !(alm_q.sec[7] || alm_q.min[7] || alm_q.hour[7] || alm_q.date[7]);

    AST_SEC_STORE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd0 && w_sec_n <= 7'd59) |=> (alm_q.sec == $past(wr_data))); // R2
    AST_SEC_REJECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd0 && w_sec_n > 7'd59) |=> $stable(alm_q.sec)); // R5
    AST_HOUR_REJECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd2 && w_hour_n > 7'd23) |=> $stable(alm_q.hour)); // R3
    AST_DATE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd3 && wr_data[4:0] == 5'd0) |=> $stable(alm_q.date)); // R4
    AST_MONTH_DATE: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && $past(no_masks)) |-> ($past(cur_date[4:0]) == $past(alm_q.date[4:0]))); // R6
    AST_SEC_MASK_FIRES: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && alm_q.sec[7]) |=> irq_pulse); // R10
    AST_PULSE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(sec_tick)); // R11

endmodule

bind rtc_alarm_ctl rtc_alarm_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .sec_tick  (sec_tick),
    .cur_date  (cur_date),
    .irq_pulse (irq_pulse),
    .alm_q     (alm_q)
);

// File: tb/rtc_alarm_ctl_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_ctl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h01;
    logic       irq_pulse;

    always #2 clk = ~clk;

    rtc_alarm_ctl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .irq_pulse(irq_pulse)
    );

    typedef struct { logic exp; string req; } item_t;
    item_t sb_q[$];
    event  samp_ev;
    int    total = 0;
    int    bad   = 0;

    // monitor: pops expected interrupt levels and compares
    initial begin
        forever begin
            @(samp_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (irq_pulse !== it.exp) begin
                    bad++;
                    $display("FAIL %s irq_pulse act=%0b exp=%0b", it.req, irq_pulse, it.exp);
                end
            end
        end
    end

    task automatic expect_irq(input logic exp, input string req);
        sb_q.push_back('{exp, req});
        ->samp_ev;
        #0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        reg_addr = a;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s slot %0d act=%02h exp=%02h", req, a, rd_data, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    endtask

    // strobe with given time; check pulse in next cycle and drop the cycle after
    task automatic tick(input logic [7:0] s, m, h, d, input logic exp, input string req);
        @(negedge clk);
        set_time(s, m, h, d);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        expect_irq(exp, req);
        @(negedge clk);
        expect_irq(1'b0, "R11");
    endtask

    task automatic load(input logic [7:0] s, m, h, d);
        wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL R11 watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_chk(2'd0, 8'h00, "R1");
        rd_chk(2'd1, 8'h00, "R1");
        rd_chk(2'd2, 8'h00, "R1");
        rd_chk(2'd3, 8'h01, "R1");
        expect_irq(1'b0, "R1");

        // R2 / R5 seconds and minutes range
        wr(2'd0, 8'h59); rd_chk(2'd0, 8'h59, "R2");
        wr(2'd0, 8'h5A); rd_chk(2'd0, 8'h59, "R5");
        wr(2'd1, 8'h60); rd_chk(2'd1, 8'h00, "R5");
        wr(2'd1, 8'hC5); rd_chk(2'd1, 8'hC5, "R2");
        // R3 hours range
        wr(2'd2, 8'h23); rd_chk(2'd2, 8'h23, "R3");
        wr(2'd2, 8'h24); rd_chk(2'd2, 8'h23, "R3");
        // R4 date range
        wr(2'd3, 8'h00); rd_chk(2'd3, 8'h01, "R4");
        wr(2'd3, 8'h19); rd_chk(2'd3, 8'h19, "R4");
        wr(2'd3, 8'h80); rd_chk(2'd3, 8'h19, "R4");

        // R6 monthly
        load(8'h30, 8'h15, 8'h12, 8'h07);
        tick(8'h30, 8'h15, 8'h12, 8'h07, 1'b1, "R6");
        tick(8'h30, 8'h15, 8'h12, 8'h08, 1'b0, "R6");
        tick(8'h31, 8'h15, 8'h12, 8'h07, 1'b0, "R6");
        // R11 matching time without a strobe
        @(negedge clk); set_time(8'h30, 8'h15, 8'h12, 8'h07);
        @(negedge clk); expect_irq(1'b0, "R11");
        @(negedge clk); expect_irq(1'b0, "R11");

        // R7 daily
        wr(2'd3, 8'h87);
        tick(8'h30, 8'h15, 8'h12, 8'h03, 1'b1, "R7");
        tick(8'h30, 8'h15, 8'h13, 8'h07, 1'b0, "R7");
        // R8 hourly
        wr(2'd2, 8'h92);
        tick(8'h30, 8'h15, 8'h05, 8'h02, 1'b1, "R8");
        tick(8'h30, 8'h16, 8'h12, 8'h07, 1'b0, "R8");
        // R9 each minute
        wr(2'd1, 8'h95);
        tick(8'h30, 8'h44, 8'h01, 8'h02, 1'b1, "R9");
        tick(8'h29, 8'h15, 8'h12, 8'h07, 1'b0, "R9");
        // R10 all masked, and an unlisted pattern (hour mask only)
        wr(2'd0, 8'hB0);
        tick(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R10");
        load(8'h30, 8'h15, 8'h92, 8'h07);
        tick(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R10");

        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule